// File: doc/BRIEF.md
# Host Access Code Decoder and Bus Datapath

This block sits between a host processor's external bus and the multiplexed address/data port of a target processor. The host does not send a target address on its own address lines. Instead, a 4-bit code on those lines names the kind of access it wants. The block turns that code and the read/write direction into a command for a separate cycle sequencer. The command says whether to run an address cycle or a data cycle, and which chip select to use: memory or I/O. The block also provides the value to drive onto the 17-line target bus, which is 16 multiplexed lines plus one extra high address line.

The target port counts in bytes. An address written by the host is therefore moved to a byte address before it reaches the bus: one place left for data memory and I/O space, two places left for program memory. Data words pass through unchanged.

For reads, the block captures the target bus on the sequencer's latch pulse. It presents the captured word to the host until the host acknowledge is withdrawn. One code returns a fixed design revision word without touching the target. Combinations that make no sense are flagged, and no target cycle is requested for them: reads of address codes, writes of the revision code, and any reserved code. The block's bus drivers stay off for these combinations so that the access can simply be acknowledged.

Top module: `vaddr_datapath`

## Requirements
- R1: While `acc_req` is high, codes 0 to 3 request a target cycle with `mem_sel_n` low, and codes 4 and 5 request one with `io_sel_n` low. Even codes (0, 2, 4) give `cmd_is_data`=0, meaning an address cycle. Odd codes (1, 3, 5) give `cmd_is_data`=1, meaning a data cycle. `cmd_rd` follows `acc_rd` (1 = read).
- R2: On an address-cycle write, `tgt_bus_out` carries `host_wdata` moved to a byte address. Codes 0 and 4 shift it left by one, so the former bit 15 lands on bus bit 16. Code 2 shifts it left by two, so the former bit 14 lands on bus bit 16 and the former bit 15 is dropped.
- R3: On a data-cycle write (codes 1, 3, 5), `tgt_bus_out` equals `host_wdata` unshifted, with bus bit 16 at 0.
- R4: A read with an address-cycle code (0, 2, 4) raises `acc_invalid`. For such a read, `cmd_valid` is 0, both chip selects are high, both driver enables are 0 and `host_rdata` is 0.
- R5: Codes 6, 7 and 9 to 15 in either direction, and a write with code 8, raise `acc_invalid` with the same quiet outputs as R4.
- R6: A read with code 8 returns the `REVISION` parameter on `host_rdata` with `host_rdata_oe`=1. It raises no chip select and sets no `cmd_valid`.
- R7: `host_rdata_oe` is 1 only during a legal read. `tgt_bus_oe` is 1 only during a legal write that requests a target cycle. Outside a drive, `tgt_bus_out` is 0.
- R8: On a clock edge with `tgt_latch` high during a legal data-cycle read, `tgt_bus_in` is captured. The captured word appears on `host_rdata` during data-cycle reads and is held while `host_ack` is high. On the first edge after `host_ack` falls, it clears to 0. A latch pulse during any other access captures nothing.
- R9: With `acc_req` low, `cmd_valid`, `acc_invalid` and both enables are 0, both selects are high, and `host_rdata` is 0.
- R10: After reset, the captured read word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Host access in progress |
| acc_code | input | 4 | Access type code from host address lines |
| acc_rd | input | 1 | 1 = host read, 0 = host write |
| host_wdata | input | 16 | Data or address from the host |
| host_rdata | output | 16 | Data returned to the host |
| host_rdata_oe | output | 1 | Enable for host data bus drivers |
| tgt_bus_in | input | 16 | Sampled target multiplexed bus |
| tgt_bus_out | output | 17 | Value for target bus (bit 16 = high address line) |
| tgt_bus_oe | output | 1 | Enable for target bus drivers |
| tgt_latch | input | 1 | Sequencer pulse to capture read data |
| host_ack | input | 1 | Acknowledge level presented to the host |
| cmd_valid | output | 1 | Request one target cycle |
| cmd_is_data | output | 1 | 1 = data cycle, 0 = address cycle |
| cmd_rd | output | 1 | Direction of the requested cycle |
| mem_sel_n | output | 1 | Memory chip select, active low |
| io_sel_n | output | 1 | I/O chip select, active low |
| acc_invalid | output | 1 | Access is illegal or reserved |

## Verification
Several properties are checked on every cycle: an illegal access stays quiet, the two chip selects never assert together, and the two driver enables never assert together. The revision read and the low two bits of a program-memory address are also checked each cycle, as is the held read word while acknowledge stays high. The exact shifted bit patterns, the high-line spill, and the loss of bit 15 for program memory are shown only by the bench's vectors. The same applies to clearing the held word after acknowledge falls and to ignoring a latch pulse during a non-data access.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

  typedef enum logic [2:0] {
    SP_DATA = 3'd0,
    SP_PROG = 3'd1,
    SP_IO   = 3'd2,
    SP_REV  = 3'd3,
    SP_NONE = 3'd4
  } space_e;

  typedef struct packed {
    space_e space;
    logic   is_data;
    logic   legal;
    logic   tgt_cycle;
  } dec_t;

  // Byte-address shift for an address cycle in a given space
  function automatic int unsigned byte_shift(space_e s);
    return (s == SP_PROG) ? 2 : 1;
  endfunction

  // Legality of a direction against a decoded space
  function automatic logic dir_legal(space_e s, logic is_data, logic rd);
    case (s)
      SP_DATA, SP_PROG, SP_IO: return is_data | ~rd;
      SP_REV:                  return rd;
      default:                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vaddr_decode.sv
module vaddr_decode
  import vaddr_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              rd,
  output dec_t              dec
);

  space_e sp;
  logic   dat;

  always_comb begin
    sp  = SP_NONE;
    dat = 1'b0;
    case (int'(code))
      0: begin sp = SP_DATA; dat = 1'b0; end
      1: begin sp = SP_DATA; dat = 1'b1; end
      2: begin sp = SP_PROG; dat = 1'b0; end
      3: begin sp = SP_PROG; dat = 1'b1; end
      4: begin sp = SP_IO;   dat = 1'b0; end
      5: begin sp = SP_IO;   dat = 1'b1; end
      8: begin sp = SP_REV;  dat = 1'b1; end
      default: begin sp = SP_NONE; dat = 1'b0; end
    endcase
  end

  always_comb begin
    dec.space     = sp;
    dec.is_data   = dat;
    dec.legal     = dir_legal(sp, dat, rd);
    dec.tgt_cycle = dir_legal(sp, dat, rd) && (sp != SP_REV) && (sp != SP_NONE);
  end

endmodule

// File: rtl/vaddr_shift.sv
module vaddr_shift
  import vaddr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BUS_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] val,
  input  space_e            space,
  input  logic              is_data,
  output logic [BUS_W-1:0]  bus
);

  logic [BUS_W:0] wide;

  always_comb begin
    wide = {2'b00, val} << byte_shift(space);
    if (is_data) bus = {1'b0, val};
    else         bus = wide[BUS_W-1:0];
  end

endmodule

// File: rtl/vaddr_rdcap.sv
module vaddr_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ack,
  output logic [DATA_W-1:0] q
);

  logic ack_q;
  logic ack_fall;

  assign ack_fall = ack_q & ~ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= ack;
      if (load)          q <= din;
      else if (ack_fall) q <= '0;
    end
  end

endmodule

// File: rtl/vaddr_datapath.sv
module vaddr_datapath
  import vaddr_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          CODE_W   = 4,
  parameter logic [15:0] REVISION = 16'h0A31,
  localparam int         BUS_W    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [CODE_W-1:0] acc_code,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  input  logic [DATA_W-1:0] tgt_bus_in,
  output logic [BUS_W-1:0]  tgt_bus_out,
  output logic              tgt_bus_oe,
  input  logic              tgt_latch,
  input  logic              host_ack,
  output logic              cmd_valid,
  output logic              cmd_is_data,
  output logic              cmd_rd,
  output logic              mem_sel_n,
  output logic              io_sel_n,
  output logic              acc_invalid
);

  dec_t              dec;
  logic [BUS_W-1:0]  shifted;
  logic [DATA_W-1:0] rd_hold;
  logic              run_cycle;
  logic              data_read;
  logic              rev_read;
  logic              cap_load;

  vaddr_decode #(.CODE_W(CODE_W)) u_dec (
    .code (acc_code),
    .rd   (acc_rd),
    .dec  (dec)
  );

  vaddr_shift #(.DATA_W(DATA_W)) u_shift (
    .val     (host_wdata),
    .space   (dec.space),
    .is_data (dec.is_data),
    .bus     (shifted)
  );

  assign run_cycle = acc_req & dec.tgt_cycle;
  assign data_read = run_cycle & acc_rd & dec.is_data;
  assign rev_read  = acc_req & dec.legal & (dec.space == SP_REV);
  assign cap_load  = data_read & tgt_latch;

  vaddr_rdcap #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cap_load),
    .din   (tgt_bus_in),
    .ack   (host_ack),
    .q     (rd_hold)
  );

  always_comb begin
    cmd_valid     = run_cycle;
    cmd_is_data   = run_cycle & dec.is_data;
    cmd_rd        = run_cycle & acc_rd;
    mem_sel_n     = ~(run_cycle & (dec.space != SP_IO));
    io_sel_n      = ~(run_cycle & (dec.space == SP_IO));
    acc_invalid   = acc_req & ~dec.legal;
    tgt_bus_oe    = run_cycle & ~acc_rd;
    tgt_bus_out   = tgt_bus_oe ? shifted : '0;
    host_rdata_oe = acc_req & dec.legal & acc_rd;
    if (rev_read)       host_rdata = DATA_W'(REVISION);
    else if (data_read) host_rdata = rd_hold;
    else                host_rdata = '0;
  end

endmodule

// File: rtl/vaddr_checker.sv
module vaddr_checker #(
  parameter int          DATA_W   = 16,
  parameter int          CODE_W   = 4,
  parameter logic [15:0] REVISION = 16'h0A31,
  localparam int         BUS_W    = DATA_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic [CODE_W-1:0] acc_code,
  input logic              acc_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rdata_oe,
  input logic [BUS_W-1:0]  tgt_bus_out,
  input logic              tgt_bus_oe,
  input logic              tgt_latch,
  input logic              host_ack,
  input logic              cmd_valid,
  input logic              mem_sel_n,
  input logic              io_sel_n,
  input logic              acc_invalid,
  input logic [DATA_W-1:0] rd_hold
);

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_sel_n && !io_sel_n)); // R1

  AST_PM_BYTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_rd && int'(acc_code) == 2) |-> tgt_bus_out[1:0] == 2'b00); // R2

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_invalid |-> (mem_sel_n && io_sel_n && !cmd_valid && !tgt_bus_oe && !host_rdata_oe)); // R4

  AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && (int'(acc_code) == 6 || int'(acc_code) == 7 || int'(acc_code) > 8)) |-> acc_invalid); // R5

  AST_REV_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_rd && int'(acc_code) == 8) |-> (host_rdata_oe && host_rdata == DATA_W'(REVISION) && !cmd_valid)); // R6

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rdata_oe && tgt_bus_oe)); // R7

  AST_HOLD_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !tgt_latch) |=> $stable(rd_hold)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (!cmd_valid && !acc_invalid && !tgt_bus_oe && !host_rdata_oe && mem_sel_n && io_sel_n)); // R9

endmodule

bind vaddr_datapath vaddr_checker #(
  .DATA_W   (DATA_W),
  .CODE_W   (CODE_W),
  .REVISION (REVISION)
) u_vaddr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_req       (acc_req),
  .acc_code      (acc_code),
  .acc_rd        (acc_rd),
  .host_rdata    (host_rdata),
  .host_rdata_oe (host_rdata_oe),
  .tgt_bus_out   (tgt_bus_out),
  .tgt_bus_oe    (tgt_bus_oe),
  .tgt_latch     (tgt_latch),
  .host_ack      (host_ack),
  .cmd_valid     (cmd_valid),
  .mem_sel_n     (mem_sel_n),
  .io_sel_n      (io_sel_n),
  .acc_invalid   (acc_invalid),
  .rd_hold       (rd_hold)
);

// File: tb/test_vaddr_datapath.sv
`timescale 1ns/1ps
module test_vaddr_datapath;

  localparam logic [15:0] REV = 16'h0A31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0;
  logic [3:0]  acc_code = '0;
  logic        acc_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rdata_oe;
  logic [15:0] tgt_bus_in = '0;
  logic [16:0] tgt_bus_out;
  logic        tgt_bus_oe;
  logic        tgt_latch = 1'b0;
  logic        host_ack = 1'b0;
  logic        cmd_valid, cmd_is_data, cmd_rd, mem_sel_n, io_sel_n, acc_invalid;

  int vec_cnt = 0;
  int bad_cnt = 0;

  always #2.5 clk = ~clk;

  vaddr_datapath #(.REVISION(REV)) i_vaddr_datapath (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_code(acc_code), .acc_rd(acc_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .tgt_bus_in(tgt_bus_in), .tgt_bus_out(tgt_bus_out), .tgt_bus_oe(tgt_bus_oe),
    .tgt_latch(tgt_latch), .host_ack(host_ack), .cmd_valid(cmd_valid),
    .cmd_is_data(cmd_is_data), .cmd_rd(cmd_rd), .mem_sel_n(mem_sel_n),
    .io_sel_n(io_sel_n), .acc_invalid(acc_invalid)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      bad_cnt++;
      $display("FAIL %s: got %h expected %h (code %0d rd %0b)", req, got, exp, acc_code, acc_rd);
    end
  endtask

  // Bench model: legality of a code/direction pair
  function automatic bit ref_legal(int c, bit rd);
    if (c <= 5) return (c % 2 == 1) || !rd;
    if (c == 8) return rd;
    return 0;
  endfunction

  // Bench model: target bus value for a write
  function automatic logic [16:0] ref_bus(int c, logic [15:0] w);
    logic [17:0] t;
    t = {2'b00, w};
    if (c % 2 == 1) return {1'b0, w};
    if (c == 2) return t[16:0] * 4;
    return t[16:0] * 2;
  endfunction

  task automatic check_comb(input bit data_rd_skip);
    int  c;
    bit  lg, tc;
    c  = int'(acc_code);
    lg = acc_req && ref_legal(c, acc_rd);
    tc = lg && c <= 5;
    if (!acc_req) check("R9 idle", {cmd_valid, acc_invalid, tgt_bus_oe, host_rdata_oe, mem_sel_n, io_sel_n}, 6'b000011);
    else if (!lg) begin
      if (c <= 5) check("R4 addr read quiet", {cmd_valid, mem_sel_n, io_sel_n, tgt_bus_oe, host_rdata_oe, host_rdata, acc_invalid}, {5'b01100, 16'h0, 1'b1});
      else        check("R5 reserved quiet", {cmd_valid, mem_sel_n, io_sel_n, tgt_bus_oe, host_rdata_oe, host_rdata, acc_invalid}, {5'b01100, 16'h0, 1'b1});
    end else if (c == 8) begin
      check("R6 revision", {host_rdata_oe, host_rdata, cmd_valid, mem_sel_n, io_sel_n}, {1'b1, REV, 3'b011});
    end else begin
      check("R1 command", {cmd_valid, cmd_is_data, cmd_rd, mem_sel_n, io_sel_n, acc_invalid},
            {1'b1, 1'(c % 2), acc_rd, (c >= 4) ? 2'b10 : 2'b01, 1'b0});
      check("R7 enables", {host_rdata_oe, tgt_bus_oe}, {acc_rd, !acc_rd});
      if (!acc_rd) begin
        if (c % 2 == 1) check("R3 data pass", tgt_bus_out, ref_bus(c, host_wdata));
        else            check("R2 addr shift", tgt_bus_out, ref_bus(c, host_wdata));
      end else check("R7 bus idle on read", tgt_bus_out, 17'h0);
    end
    if (!tc || acc_rd) if (!(lg && !acc_rd)) if (tgt_bus_out !== 17'h0) check("R7 bus zero", tgt_bus_out, 17'h0);
    if (data_rd_skip) ;
  endtask

  task automatic setv(input bit req, input int c, input bit rd, input logic [15:0] w);
    acc_req = req; acc_code = 4'(c); acc_rd = rd; host_wdata = w;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R10: captured word zero after reset, seen through a data read
    setv(1, 1, 1, 16'h0); #1;
    check("R10 reset hold", host_rdata, 16'h0);
    setv(0, 0, 0, 16'h0); #1;
    check_comb(0);

    // Directed corner cases for shifts (R2/R3)
    setv(1, 0, 0, 16'h8001); #1; check("R2 dm spill", tgt_bus_out, 17'h10002);
    setv(1, 4, 0, 16'hC000); #1; check("R2 io spill", tgt_bus_out, 17'h18000);
    setv(1, 2, 0, 16'hC001); #1; check("R2 pm drop15", tgt_bus_out, 17'h10004);
    setv(1, 3, 0, 16'hFFFF); #1; check("R3 pm data", tgt_bus_out, 17'h0FFFF);
    setv(1, 8, 0, 16'h1234); #1; check("R5 rev write", {acc_invalid, host_rdata_oe}, 2'b10);

    // Random combinational sweep
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      setv($urandom_range(0, 7) != 0, $urandom_range(0, 15), $urandom_range(0, 1), 16'($urandom));
      #1;
      if (!(acc_req && acc_rd && int'(acc_code) <= 5 && int'(acc_code) % 2 == 1)) check_comb(0);
      else check_comb(1);
    end

    // R8 capture, hold, clear
    @(negedge clk);
    setv(1, 1, 1, 16'h0); tgt_bus_in = 16'hABCD; tgt_latch = 1;
    @(negedge clk); tgt_latch = 0; tgt_bus_in = 16'h1111; host_ack = 1;
    check("R8 capture", host_rdata, 16'hABCD);
    @(negedge clk); @(negedge clk);
    check("R8 hold", host_rdata, 16'hABCD);
    host_ack = 0;
    @(negedge clk);
    check("R8 clear on ack fall", host_rdata, 16'h0);

    // R8 latch during address write / invalid read captures nothing
    setv(1, 0, 1, 16'h0); tgt_bus_in = 16'h5A5A; tgt_latch = 1;
    @(negedge clk);
    setv(1, 2, 0, 16'h0077);
    @(negedge clk); tgt_latch = 0;
    setv(1, 3, 1, 16'h0); #1;
    check("R8 no capture outside data read", host_rdata, 16'h0);

    // R8 program-memory read capture
    tgt_bus_in = 16'h7E81; tgt_latch = 1;
    @(negedge clk); tgt_latch = 0;
    check("R8 pm capture", host_rdata, 16'h7E81);
    setv(1, 5, 1, 16'h0); #1;
    check("R8 io read shows hold", host_rdata, 16'h7E81);

    setv(0, 0, 0, 16'h0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule